// File: doc/BRIEF.md
# Audio master clock ratio generator

This block turns a core audio clock into the three clocks that a stereo serial audio link needs. These are an oversampled master clock (MCLK) for the external converter, a bit clock and a frame (left/right) clock. The core clock `clk` ticks twice per period of the serial-audio source clock. That source clock runs either at 512 times the sample rate or at 384 times the sample rate, and `base_tri` tells the block which. So one frame, which is one sample period, lasts 1024 core ticks in the first family and 768 core ticks in the second.

A three-bit `mult_code` picks the MCLK ratio by halving the source rate `mult_code` times. The same code therefore gives a power-of-two ratio from 512 or a three-halves-scaled ratio from 384, depending on the family. The outputs run while `run` is high and `gate` is low. Stopping silences MCLK at once, but the bit and frame clocks finish the frame in progress. Configuration is sampled only when the block starts and at frame boundaries, so MCLK never shows a runt pulse when the ratio is changed on the fly.

Top module: `mclk_ratio_gen`

## Requirements
- R1: After reset, with no enable request, `mclk`, `bclk`, `fclk`, `busy` and `cfg_err` are all low.
- R2: The enable request is `run`=1 with `gate`=0. When it is seen at a clock edge while idle, `busy` goes high after that edge and that cycle is tick 0 of a new frame. `mclk`, `bclk` and `fclk` are low in tick 0.
- R3: With `base_tri`=0 and code k in 0..4, the frame is 1024 ticks long. `mclk` equals bit k of the tick index, so its period is 2^(k+1) ticks with 50% duty, giving ratios of 512, 256, 128, 64 and 32 times fs.
- R4: With `base_tri`=1 and code k in 0..3, the frame is 768 ticks long and `mclk` equals bit k of the tick index, giving ratios of 384, 192, 96 and 48 times fs.
- R5: Code 4 with `base_tri`=1 is illegal, and so are codes 5 to 7 in either family. While such a configuration is active, `cfg_err` is high and `mclk` stays low. The bit and frame clocks keep running.
- R6: There are 64 bit-clock periods per frame, each 16 ticks long (`base_tri`=0) or 12 ticks long (`base_tri`=1). `bclk` is low for the first half of each period and high for the second half.
- R7: `fclk` is low for the first 32 bit periods of a frame and high for the last 32.
- R8: Changes on `base_tri` or `mult_code` take effect only at the next start or frame boundary. Within a frame, the outputs follow the configuration latched at its tick 0.
- R9: When the enable request drops, `mclk` is low from the next edge on. `busy`, `bclk` and `fclk` continue until the last tick of the current frame. If the request is still absent at that edge, all outputs go low.
- R10: If the request returns before the frame ends, the frame continues without restarting and `mclk` again follows the tick index from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, two ticks per source-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run request |
| gate | input | 1 | Clock gate; high stops the outputs like clearing run |
| base_tri | input | 1 | Family select: 0 = 512×fs source, 1 = 384×fs source |
| mult_code | input | 3 | MCLK ratio code: the source rate halved this many times |
| mclk | output | 1 | Oversampled master clock |
| bclk | output | 1 | Bit clock, 64 periods per frame |
| fclk | output | 1 | Frame clock, low for left half, high for right half |
| busy | output | 1 | High while a frame is being generated |
| cfg_err | output | 1 | Active configuration is illegal |

## Verification
The assertions assume that `run`, `gate`, `base_tri` and `mult_code` are synchronous to `clk` and settled before each rising edge. They make no assumption about when the configuration changes relative to a frame. The stimulus therefore changes every input only on the falling clock edge. It deliberately changes the code and family in the middle of frames, and it drops and restores the enable request in the middle of frames, so that the boundary-latching and drain behaviour is driven from arbitrary tick positions.

// File: rtl/mclk_ratio_gen.sv
module mclk_ratio_gen #(
  parameter int SLOT_BITS    = 32,
  parameter int RATIO_PO2    = 512,
  parameter int RATIO_TRI    = 384,
  parameter int CODE_W       = 3,
  parameter int TOP_CODE_PO2 = 4,
  parameter int TOP_CODE_TRI = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              gate,
  input  logic              base_tri,
  input  logic [CODE_W-1:0] mult_code,
  output logic              mclk,
  output logic              bclk,
  output logic              fclk,
  output logic              busy,
  output logic              cfg_err
);

  localparam int FRAME_PO2  = 2 * RATIO_PO2;
  localparam int FRAME_TRI  = 2 * RATIO_TRI;
  localparam int BITS_FRAME = 2 * SLOT_BITS;
  localparam int BIT_PO2    = FRAME_PO2 / BITS_FRAME;
  localparam int BIT_TRI    = FRAME_TRI / BITS_FRAME;
  localparam int TW         = $clog2(FRAME_PO2);
  localparam int PW         = $clog2(BIT_PO2);
  localparam int IW         = $clog2(BITS_FRAME);

  logic              act, run_q, cfg_tri;
  logic [CODE_W-1:0] cfg_code;
  logic [TW-1:0]     tcnt;
  logic [PW-1:0]     bph;
  logic [IW-1:0]     bidx;

  wire          req       = run & ~gate;
  wire [TW-1:0] tlast     = cfg_tri ? TW'(FRAME_TRI - 1) : TW'(FRAME_PO2 - 1);
  wire [PW-1:0] plast     = cfg_tri ? PW'(BIT_TRI - 1)   : PW'(BIT_PO2 - 1);
  wire [PW-1:0] phalf     = cfg_tri ? PW'(BIT_TRI / 2)   : PW'(BIT_PO2 / 2);
  wire          frame_end = act && (tcnt == tlast);
  wire          bad       = cfg_code > (cfg_tri ? CODE_W'(TOP_CODE_TRI) : CODE_W'(TOP_CODE_PO2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      run_q    <= 1'b0;
      cfg_tri  <= 1'b0;
      cfg_code <= '0;
      tcnt     <= '0;
      bph      <= '0;
      bidx     <= '0;
    end else begin
      run_q <= req;
      if (!act || frame_end) begin
        tcnt <= '0;
        bph  <= '0;
        bidx <= '0;
        if (req || frame_end) begin
          act      <= req;
          cfg_tri  <= base_tri;
          cfg_code <= mult_code;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
        if (bph == plast) begin
          bph  <= '0;
          bidx <= bidx + 1'b1;
        end else begin
          bph <= bph + 1'b1;
        end
      end
    end
  end

  assign mclk    = act & run_q & ~bad & tcnt[cfg_code];
  assign bclk    = act & (bph >= phalf);
  assign fclk    = act & bidx[IW-1];
  assign busy    = act;
  assign cfg_err = act & bad;

  // R9
  mclk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !mclk);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(req));

  // R2
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req) && !mclk && !bclk && !fclk);

  // R5
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !mclk);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && tcnt != '0) |-> $stable(cfg_code) && $stable(cfg_tri));

  // R7
  fclk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclk) |-> !bclk);

endmodule

// File: tb/mclk_ratio_gen_test.sv
module mclk_ratio_gen_test;

  typedef struct {
    logic  m, b, f, y, e;
    string tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, gate = 1'b0, base_tri = 1'b0;
  logic [2:0] mult_code = 3'd0;
  logic mclk, bclk, fclk, busy, cfg_err;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  item_t exp_q[$];

  int m_act = 0, m_t = 0, m_tri = 0, m_code = 0, m_runq = 0;

  always #4 clk = ~clk;

  mclk_ratio_gen uut (
    .clk(clk), .rst_n(rst_n), .run(run), .gate(gate), .base_tri(base_tri),
    .mult_code(mult_code), .mclk(mclk), .bclk(bclk), .fclk(fclk),
    .busy(busy), .cfg_err(cfg_err)
  );

  function automatic int flen(int tri_sel);
    return tri_sel ? 768 : 1024;
  endfunction

  function automatic int blen(int tri_sel);
    return tri_sel ? 12 : 16;
  endfunction

  function automatic bit illegal(int tri_sel, int code);
    return tri_sel ? (code > 3) : (code > 4);
  endfunction

  task automatic step(input bit r, input bit g, input bit tri_sel, input int code, input string tag);
    item_t it;
    int en, bl;
    @(negedge clk);
    run = r; gate = g; base_tri = tri_sel; mult_code = 3'(code);
    en = (r && !g) ? 1 : 0;
    if (m_act == 0) begin
      if (en != 0) begin m_act = 1; m_t = 0; m_tri = tri_sel; m_code = code; end
    end else if (m_t == flen(m_tri) - 1) begin
      m_act = en; m_t = 0; m_tri = tri_sel; m_code = code;
    end else begin
      m_t++;
    end
    m_runq = en;
    bl = blen(m_tri);
    it.y = (m_act != 0);
    it.e = (m_act != 0) && illegal(m_tri, m_code);
    it.b = (m_act != 0) && ((m_t % bl) >= bl / 2);
    it.f = (m_act != 0) && ((m_t / bl) >= 32);
    it.m = (m_act != 0) && (m_runq != 0) && !illegal(m_tri, m_code) && (((m_t >> m_code) & 1) == 1);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drive(input bit r, input bit g, input bit tri_sel, input int code, input int n, input string tag);
    for (int i = 0; i < n; i++) step(r, g, tri_sel, code, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if ({mclk, bclk, fclk, busy, cfg_err} !== {it.m, it.b, it.f, it.y, it.e}) begin
          fails++;
          $display("FAIL %s check %0d: mclk/bclk/fclk/busy/err actual=%b%b%b%b%b expected=%b%b%b%b%b",
                   it.tag, checks, mclk, bclk, fclk, busy, cfg_err, it.m, it.b, it.f, it.y, it.e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 20,   "R1");
    drive(1, 0, 0, 0, 1500, "R2 R3 R6 R7");
    drive(1, 0, 0, 1, 1024, "R3 R8");
    drive(1, 0, 0, 2, 1024, "R3 R8");
    drive(1, 0, 0, 3, 1024, "R3");
    drive(1, 0, 0, 4, 1024, "R3");
    drive(1, 0, 1, 0, 768,  "R4 R6 R7 R8");
    drive(1, 0, 1, 1, 768,  "R4");
    drive(1, 0, 1, 2, 768,  "R4");
    drive(1, 0, 1, 3, 768,  "R4");
    drive(1, 0, 1, 4, 900,  "R5");
    drive(1, 0, 0, 6, 1100, "R5");
    drive(1, 0, 0, 2, 1100, "R3 R8");
    drive(0, 0, 0, 2, 1100, "R9");
    drive(1, 0, 1, 1, 500,  "R2 R4");
    drive(1, 1, 1, 1, 40,   "R9");
    drive(1, 0, 1, 1, 900,  "R10");
    drive(1, 1, 1, 1, 900,  "R9");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule